// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM and walks the memory's command bus through its mandatory start-up procedure after every reset. It holds the clock-enable pin low and sends only NOP while a programmable power-up delay runs. The delay is set in microseconds and turned into cycles with the clock-frequency parameter. The block then raises clock-enable and issues a fixed series of single-cycle commands: precharge of all banks, an extended mode load that enables the DLL, a base mode load that resets the DLL and programs burst length, burst type and CAS latency, a second precharge-all, two auto-refreshes, and a last base mode load with the DLL-reset bit cleared.

Parameterized down-counters enforce the gaps between commands: precharge recovery, mode-load delay and refresh recovery. A separate counter guards the DLL lock window that starts at the DLL-reset load. The done flag rises only when both the last mode-load delay and the DLL window have run out. After that the block drives NOP for good, and the normal traffic scheduler may take over the bus. Pulling the reset low at any time returns the block to the clock-enable-low wait and clears the done flag.

Top module: `ddr_init_seq`

## Requirements
- R1: From reset release, `cke` stays 0 and the command pins {cs_n,ras_n,cas_n,we_n} hold NOP = 4'b0111 for at least STARTUP_CYC = CLK_MHZ*STARTUP_US cycles. `cke` rises no later than STARTUP_CYC+4 cycles after release. While reset is held, `cke` and `init_done` are 0.
- R2: The cycle in which `cke` first goes high carries NOP. One cycle later, PRECHARGE ALL is issued: pins 4'b0010, `addr`[10]=1 and all other address bits 0, `ba`=0.
- R3: Exactly T_RP cycles after the first precharge, an extended mode load is issued: pins 4'b0000, `ba`=2'b01, `addr`=0. Bit 0 at 0 means the DLL is enabled.
- R4: Exactly T_MRD cycles after the extended load, a base mode load is issued with `ba`=2'b00. Its address fields are: bits [2:0] hold the burst-length code (2→1, 4→2, 8→3), bit 3 the burst type, bits [6:4] CAS_CODE, and bit 8 = 1 (DLL reset). All other bits are 0.
- R5: After the DLL-reset load, the order and exact gaps are: PRECHARGE ALL after T_MRD, AUTO REFRESH (pins 4'b0001, `addr`=0, `ba`=0) after T_RP, a second AUTO REFRESH after T_RFC, then the final base mode load after T_RFC. The final load carries the same fields as in R4 but with bit 8 = 0.
- R6: Every non-NOP command lasts exactly one cycle, and the cycle after it carries NOP.
- R7: `init_done` rises exactly max(t_dllrst + T_DLL, t_final + T_MRD), where t_dllrst and t_final are the issue cycles of the two base mode loads. It then stays 1, and no further command other than NOP is issued.
- R8: Once `cke` is high, it falls only when reset is asserted. A reset asserted mid-sequence forces `cke`=0, `init_done`=0 and NOP immediately. After release, the whole sequence of R1 to R7 runs again from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, CLK_MHZ MHz |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address, selects base (00) or extended (01) mode register |
| addr | output | 13 | Address bus, carries mode words and the all-bank precharge bit |
| init_done | output | 1 | High once normal traffic may begin |

## Verification
Every command pin comes from a single output register stage, and so does `init_done`. A command is therefore visible one cycle after the state that issues it, and the gaps between commands equal the state-level gaps. The monitor samples on the falling edge, stamps each non-NOP command with the cycle count, and compares that cycle with the previous command's cycle, using the exact gap from R3 to R5. The clock-enable rise is measured against the cycle of reset release and must fall in a window that covers the two-stage reset synchronizer. The done rise is checked against the larger of the two deadlines in R7, both computed from the stamps the monitor recorded.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  // sequencer states
  typedef enum logic [4:0] {
    S_PWR, S_CKE,
    S_PRE1, S_W_PRE1,
    S_EMR, S_W_EMR,
    S_MRR, S_W_MRR,
    S_PRE2, S_W_PRE2,
    S_REF1, S_W_REF1,
    S_REF2, S_W_REF2,
    S_MRF, S_W_MRF,
    S_DONE
  } seq_state_e;

  // abstract command kinds handed to the encoder
  typedef enum logic [2:0] {
    K_NOP, K_PRE_ALL, K_REFRESH, K_LOAD_EXT, K_LOAD_RST, K_LOAD_FIN
  } cmd_kind_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PINS_NOP     = 4'b0111;
  localparam logic [3:0] PINS_PRE     = 4'b0010;
  localparam logic [3:0] PINS_REFRESH = 4'b0001;
  localparam logic [3:0] PINS_LOAD    = 4'b0000;

  localparam int ALLBANK_BIT = 10;
  localparam int DLLRST_BIT  = 8;

  function automatic logic [2:0] bl_code(input int bl);
    case (bl)
      2:       bl_code = 3'd1;
      8:       bl_code = 3'd3;
      default: bl_code = 3'd2;
    endcase
  endfunction

  function automatic logic [12:0] mode_word(input int bl, input logic bt,
                                            input logic [2:0] cas, input logic dll_rst);
    logic [12:0] w;
    w = '0;
    w[2:0] = bl_code(bl);
    w[3] = bt;
    w[6:4] = cas;
    w[DLLRST_BIT] = dll_rst;
    mode_word = w;
  endfunction

  function automatic int max2(input int a, input int b);
    max2 = (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_init_rst_sync.sv
module ddr_init_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] shift_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n_i) begin
        if (!rst_n_i) shift_q <= '0;
        else          shift_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n_i) begin
        if (!rst_n_i) shift_q <= '0;
        else          shift_q <= {shift_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_o = shift_q[STAGES-1];
endmodule

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int            W       = 8,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RST_VAL;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // once expired the timer stays expired until reloaded
  p_hold_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);
endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
#(
  parameter int         ADDR_W     = 13,
  parameter int         BURST_LEN  = 4,
  parameter logic       BURST_TYPE = 1'b0,
  parameter logic [2:0] CAS_CODE   = 3'b011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_kind_e         kind,
  input  logic              cke_en,
  input  logic              done_en,
  output logic              cke,
  output logic [3:0]        pins,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);
  localparam logic [12:0] MW_RST = mode_word(BURST_LEN, BURST_TYPE, CAS_CODE, 1'b1);
  localparam logic [12:0] MW_FIN = mode_word(BURST_LEN, BURST_TYPE, CAS_CODE, 1'b0);

  logic [3:0]        pins_d;
  logic [1:0]        ba_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    pins_d = PINS_NOP;
    ba_d   = 2'b00;
    addr_d = '0;
    case (kind)
      K_PRE_ALL: begin
        pins_d = PINS_PRE;
        addr_d[ALLBANK_BIT] = 1'b1;
      end
      K_REFRESH:  pins_d = PINS_REFRESH;
      K_LOAD_EXT: begin
        pins_d = PINS_LOAD;
        ba_d   = 2'b01;
      end
      K_LOAD_RST: begin
        pins_d = PINS_LOAD;
        addr_d = ADDR_W'(MW_RST);
      end
      K_LOAD_FIN: begin
        pins_d = PINS_LOAD;
        addr_d = ADDR_W'(MW_FIN);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke       <= 1'b0;
      pins      <= PINS_NOP;
      ba        <= 2'b00;
      addr      <= '0;
      init_done <= 1'b0;
    end else begin
      cke       <= cke_en;
      pins      <= pins_d;
      ba        <= ba_d;
      addr      <= addr_d;
      init_done <= done_en;
    end
  end

  p_nop_cke_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (pins == PINS_NOP));
  p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pins != PINS_NOP) |=> (pins == PINS_NOP));
  p_quiet_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (pins == PINS_NOP));
  p_bl_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == PINS_LOAD && ba == 2'b00) |-> (addr[2:0] inside {3'd1, 3'd2, 3'd3}));
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int         CLK_MHZ    = 50,
  parameter int         STARTUP_US = 200,
  parameter int         T_RP       = 3,
  parameter int         T_MRD      = 2,
  parameter int         T_RFC      = 10,
  parameter int         T_DLL      = 200,
  parameter int         BURST_LEN  = 4,
  parameter logic       BURST_TYPE = 1'b0,
  parameter logic [2:0] CAS_CODE   = 3'b011,
  parameter int         ADDR_W     = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);
  localparam int STARTUP_CYC = CLK_MHZ * STARTUP_US;
  localparam int MAXV = max2(max2(STARTUP_CYC, T_DLL), max2(T_RFC, max2(T_RP, T_MRD)));
  localparam int CW   = $clog2(MAXV + 1);
  localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 2);
  localparam logic [CW-1:0] LD_MRD = CW'(T_MRD - 2);
  localparam logic [CW-1:0] LD_RFC = CW'(T_RFC - 2);
  localparam logic [CW-1:0] LD_DLL = CW'(T_DLL - 2);

  logic       rst_int_n;
  seq_state_e state_q, state_d;
  logic          gap_load, dll_load, gap_zero, dll_zero;
  logic [CW-1:0] gap_val;
  cmd_kind_e  kind;
  logic [3:0] pins;

  ddr_init_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_int_n)
  );

  // gap timer doubles as the power-up delay counter out of reset
  ddr_init_timer #(.W(CW), .RST_VAL(CW'(STARTUP_CYC - 1))) u_gap (
    .clk(clk), .rst_n(rst_int_n), .load(gap_load), .load_val(gap_val), .zero(gap_zero)
  );

  ddr_init_timer #(.W(CW), .RST_VAL({CW{1'b1}})) u_dll (
    .clk(clk), .rst_n(rst_int_n), .load(dll_load), .load_val(LD_DLL), .zero(dll_zero)
  );

  // next-state and command selection
  always_comb begin
    state_d  = state_q;
    gap_load = 1'b0;
    gap_val  = LD_RP;
    dll_load = 1'b0;
    kind     = K_NOP;
    case (state_q)
      S_PWR:    if (gap_zero) state_d = S_CKE;
      S_CKE:    state_d = S_PRE1;
      S_PRE1: begin
        kind = K_PRE_ALL; gap_load = 1'b1; gap_val = LD_RP; state_d = S_W_PRE1;
      end
      S_W_PRE1: if (gap_zero) state_d = S_EMR;
      S_EMR: begin
        kind = K_LOAD_EXT; gap_load = 1'b1; gap_val = LD_MRD; state_d = S_W_EMR;
      end
      S_W_EMR:  if (gap_zero) state_d = S_MRR;
      S_MRR: begin
        kind = K_LOAD_RST; gap_load = 1'b1; gap_val = LD_MRD; dll_load = 1'b1;
        state_d = S_W_MRR;
      end
      S_W_MRR:  if (gap_zero) state_d = S_PRE2;
      S_PRE2: begin
        kind = K_PRE_ALL; gap_load = 1'b1; gap_val = LD_RP; state_d = S_W_PRE2;
      end
      S_W_PRE2: if (gap_zero) state_d = S_REF1;
      S_REF1: begin
        kind = K_REFRESH; gap_load = 1'b1; gap_val = LD_RFC; state_d = S_W_REF1;
      end
      S_W_REF1: if (gap_zero) state_d = S_REF2;
      S_REF2: begin
        kind = K_REFRESH; gap_load = 1'b1; gap_val = LD_RFC; state_d = S_W_REF2;
      end
      S_W_REF2: if (gap_zero) state_d = S_MRF;
      S_MRF: begin
        kind = K_LOAD_FIN; gap_load = 1'b1; gap_val = LD_MRD; state_d = S_W_MRF;
      end
      S_W_MRF:  if (gap_zero && dll_zero) state_d = S_DONE;
      S_DONE:   state_d = S_DONE;
      default:  state_d = S_PWR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= S_PWR;
    else            state_q <= state_d;
  end

  ddr_init_cmd_enc #(
    .ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN), .BURST_TYPE(BURST_TYPE), .CAS_CODE(CAS_CODE)
  ) u_enc (
    .clk(clk), .rst_n(rst_int_n), .kind(kind),
    .cke_en(state_q != S_PWR), .done_en(state_q == S_DONE),
    .cke(cke), .pins(pins), .ba(ba), .addr(addr), .init_done(init_done)
  );

  assign {cs_n, ras_n, cas_n, we_n} = pins;

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    init_done |=> init_done);
  p_done_after_dll_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    init_done |-> dll_zero);
  p_cke_holds_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    cke |=> cke);
endmodule

// File: tb/test_ddr_init_seq.sv
module test_ddr_init_seq;
  localparam int CLK_MHZ = 50, STARTUP_US = 200;
  localparam int STARTUP_CYC = CLK_MHZ * STARTUP_US;
  localparam int T_RP = 3, T_MRD = 2, T_RFC = 9, T_DLL = 200, BL = 8;
  localparam logic [2:0] CAS = 3'b011;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, LMR = 4'b0000;
  localparam logic [12:0] MW_FIN = 13'h033;   // BL8 code 3, seq, CL code 3
  localparam logic [12:0] MW_RST = 13'h133;   // same plus DLL reset bit 8

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0] ba;
  logic [12:0] addr;
  logic [3:0] cmd;

  int errors = 0, checks = 0;
  longint cyc = 0, rel_cyc = 0;

  typedef struct { logic [3:0] c; logic [1:0] b; logic [12:0] a; int gap; int kind; } item_t;
  item_t  expq[$];
  string  tagq[$];

  ddr_init_seq #(.CLK_MHZ(CLK_MHZ), .STARTUP_US(STARTUP_US), .T_RP(T_RP), .T_MRD(T_MRD),
                 .T_RFC(T_RFC), .T_DLL(T_DLL), .BURST_LEN(BL), .CAS_CODE(CAS)) i_ddr_init_seq (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done));

  assign cmd = {cs_n, ras_n, cas_n, we_n};

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] c, input logic [1:0] b, input logic [12:0] a,
                      input int gap, input int kind, input string tag);
    item_t it;
    it.c = c; it.b = b; it.a = a; it.gap = gap; it.kind = kind;
    expq.push_back(it);
    tagq.push_back(tag);
  endtask

  task automatic push_all();
    expq.delete(); tagq.delete();
    push(PRE, 2'b00, 13'h400, 1,     0, "R2 first precharge");
    push(LMR, 2'b01, 13'h000, T_RP,  0, "R3 extended load");
    push(LMR, 2'b00, MW_RST,  T_MRD, 1, "R4 dll reset load");
    push(PRE, 2'b00, 13'h400, T_MRD, 0, "R5 second precharge");
    push(REF, 2'b00, 13'h000, T_RP,  3, "R5 refresh 1");
    push(REF, 2'b00, 13'h000, T_RFC, 0, "R5 refresh 2");
    push(LMR, 2'b00, MW_FIN,  T_RFC, 2, "R5 final load");
  endtask

  // monitor state
  bit prev_cke = 0, prev_done = 0, nop_next = 0, ref1_seen = 0, done_seen = 0;
  int low_bad = 0;
  longint t_last = 0, t_rst = 0, t_fin = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (nop_next) begin
        chk(cmd == NOP, "R6 nop after command", cmd, NOP);
        nop_next = 0;
      end
      if (!cke && cmd != NOP) low_bad++;
      if (!cke && prev_cke) chk(0, "R8 cke fell without reset", 0, 1);
      if (cke && !prev_cke) begin
        chk(cyc - rel_cyc >= STARTUP_CYC && cyc - rel_cyc <= STARTUP_CYC + 4,
            "R1 power-up wait length", cyc - rel_cyc, STARTUP_CYC);
        chk(low_bad == 0, "R1 only nop while cke low", low_bad, 0);
        chk(cmd == NOP, "R2 nop with cke rise", cmd, NOP);
        t_last = cyc;
      end
      if (cmd != NOP) begin
        if (expq.size() == 0) begin
          chk(0, "R7 unexpected command", cmd, NOP);
        end else begin
          item_t it;
          string tg;
          it = expq.pop_front();
          tg = tagq.pop_front();
          chk(cmd == it.c,  {tg, " pins"}, cmd, it.c);
          chk(ba == it.b,   {tg, " bank"}, ba, it.b);
          chk(addr == it.a, {tg, " addr"}, addr, it.a);
          chk(cyc - t_last == it.gap, {tg, " gap"}, cyc - t_last, it.gap);
          if (it.kind == 1) t_rst = cyc;
          if (it.kind == 2) t_fin = cyc;
          if (it.kind == 3) ref1_seen = 1;
        end
        t_last = cyc;
        nop_next = 1;
      end
      if (init_done && !prev_done) begin
        longint exp_t;
        exp_t = (t_rst + T_DLL > t_fin + T_MRD) ? t_rst + T_DLL : t_fin + T_MRD;
        chk(cyc == exp_t, "R7 done rise cycle", cyc, exp_t);
        chk(expq.size() == 0, "R7 all commands issued before done", expq.size(), 0);
        done_seen = 1;
      end
      if (!init_done && prev_done) chk(0, "R7 done fell", 0, 1);
      prev_cke = cke;
      prev_done = init_done;
    end else begin
      prev_cke = 0; prev_done = 0; nop_next = 0; low_bad = 0;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    wait (cyc == 60000);
    chk(0, "watchdog expired", cyc, 0);
    finish_run();
  end

  task automatic release_reset();
    @(posedge clk); #2;
    rel_cyc = cyc;
    rst_n = 1'b1;
  endtask

  initial begin
    push_all();
    repeat (4) @(negedge clk);
    chk(cke == 0, "R1 cke low in reset", cke, 0);
    chk(init_done == 0, "R1 done low in reset", init_done, 0);
    release_reset();
    // interrupt the first run after the first refresh
    wait (ref1_seen);
    @(posedge clk); #2;
    rst_n = 1'b0;
    @(negedge clk);
    chk(cke == 0, "R8 cke low after mid reset", cke, 0);
    chk(init_done == 0, "R8 done low after mid reset", init_done, 0);
    chk(cmd == NOP, "R8 nop after mid reset", cmd, NOP);
    push_all();
    t_rst = 0; t_fin = 0;
    repeat (3) @(negedge clk);
    release_reset();
    wait (done_seen);
    repeat (300) @(negedge clk);
    chk(init_done == 1, "R7 done still high", init_done, 1);
    chk(cke == 1, "R8 cke still high", cke, 1);
    chk(cmd == NOP, "R7 bus idle after done", cmd, NOP);
    finish_run();
  end
endmodule